// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block models a field-programmable two-level logic plane. A set of array inputs is expanded into true and inverted columns, and a configurable AND plane forms product terms from any chosen subset of those columns. The product terms are gathered in fixed groups, one group per output, and each group is ORed into a sum. Every output also carries a mode bit. In split mode, the last term of its group is removed from the sum and handed out as a buffer-enable term, so that an output stage downstream can drive its pin from it.

The connection map and the per-output mode bits are written through a serial shift port into a shadow register, and a load strobe copies the shadow into the active configuration in a single step. Until that strobe arrives, the array keeps computing with the previous configuration. Product terms, sums, the per-term sum mask and the enable terms are combinational functions of the array inputs and the active configuration.

Top module: `sop_array`

## Requirements
- R1: Input i drives column 2i with its true value and column 2i+1 with its inverse. A product term is the AND of every column whose connection bit is set.
- R2: A product term with no connection bit set reads 1, whatever the inputs are.
- R3: A product term that connects both columns of the same input reads 0, whatever the inputs are.
- R4: Output o owns terms o*TPO through o*TPO+TPO-1. sum_o[o] is the OR of the terms in that group whose sum_mask_o bit is set, and sum_mask_o reports this selection term by term.
- R5: With its mode bit at 0 (all-sum), an output adds every term of its group, and its oe_term_o bit is 0.
- R6: With its mode bit at 1 (split), an output leaves the last term of its group out of the sum, and oe_term_o[o] carries that term's value.
- R7: Shifting the serial port changes no output. The active configuration changes only at a clock edge with cfg_load_i high.
- R8: Configuration layout: configuration vector bit o is the mode bit of output o, and bit N_OUT + t*2*N_IN + c is the connection of term t to column c. Each shift enters cfg_sdi_i at bit 0 and moves the vector up one place, so a full load sends bit CFG_W-1 first.
- R9: Reset clears the shadow and the active configuration. As a result all terms read 1, all sums read 1, all mask bits read 1 and all enable terms read 0.
- R10: When shift and load coincide in one cycle, the active configuration takes the shadow contents from before that cycle's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_i | input | N_IN | Array inputs |
| cfg_sdi_i | input | 1 | Serial configuration data |
| cfg_shift_i | input | 1 | Shift one bit into the shadow |
| cfg_load_i | input | 1 | Copy the shadow into the active configuration |
| pterm_o | output | N_OUT*TPO | Raw product-term values |
| sum_o | output | N_OUT | OR sum for each output |
| sum_mask_o | output | N_OUT*TPO | 1 where a term feeds its output's sum |
| oe_term_o | output | N_OUT | Enable term for each output that is in split mode, else 0 |

## Verification
The bench builds the block with its default sizes: 16 inputs, 8 outputs and 8 terms per output, which makes a 2056-bit configuration chain. At this size every column of every term and every output's mode bit is loaded serially in full, MSB first. Sparse random maps with random mode bits produce empty terms, contradictory terms and mixed split and all-sum groups. Directed maps pin down the true/complement column order, hold the old map during a partial shift, and cover a shift and a load in the same cycle.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic {
        GRP_ALL_SUM  = 1'b0,
        GRP_SPLIT_OE = 1'b1
    } grp_mode_e;

    // Column pair for one input: bit 0 true, bit 1 inverted
    function automatic logic [1:0] col_pair(input logic x);
        return {~x, x};
    endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi_i,
    input  logic         shift_i,
    input  logic         load_i,
    output logic [W-1:0] active_o
);

    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] active;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.active = st_q.shadow;
        end
        if (shift_i) begin
            st_d.shadow = {st_q.shadow[W-2:0], sdi_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_COLS  = 32,
    parameter int N_TERMS = 64
) (
    input  logic [N_COLS-1:0]         cols_i,
    input  logic [N_TERMS*N_COLS-1:0] map_i,
    output logic [N_TERMS-1:0]        pterm_o
);

    // A disconnected column contributes 1, so an empty row gives 1 and
    // a row holding both polarities of one input gives 0.
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        assign pterm_o[t] = &(~map_i[t*N_COLS +: N_COLS] | cols_i);
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int TPO   = 8
) (
    input  logic [N_OUT*TPO-1:0] pterm_i,
    input  logic [N_OUT-1:0]     mode_i,
    output logic [N_OUT-1:0]     sum_o,
    output logic [N_OUT*TPO-1:0] sum_mask_o,
    output logic [N_OUT-1:0]     oe_term_o
);

    localparam logic [TPO-1:0] MASK_SPLIT = {1'b0, {(TPO-1){1'b1}}};

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [TPO-1:0] grp;
        logic [TPO-1:0] mask;
        logic           split;

        assign grp   = pterm_i[o*TPO +: TPO];
        assign split = (grp_mode_e'(mode_i[o]) == GRP_SPLIT_OE);
        assign mask  = split ? MASK_SPLIT : '1;

        assign sum_mask_o[o*TPO +: TPO] = mask;
        assign sum_o[o]                 = |(grp & mask);
        assign oe_term_o[o]             = split & grp[TPO-1];
    end

endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int N_IN  = 16,
    parameter int N_OUT = 8,
    parameter int TPO   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IN-1:0]      in_i,
    input  logic                 cfg_sdi_i,
    input  logic                 cfg_shift_i,
    input  logic                 cfg_load_i,
    output logic [N_OUT*TPO-1:0] pterm_o,
    output logic [N_OUT-1:0]     sum_o,
    output logic [N_OUT*TPO-1:0] sum_mask_o,
    output logic [N_OUT-1:0]     oe_term_o
);

    localparam int N_COLS  = 2 * N_IN;
    localparam int N_TERMS = N_OUT * TPO;
    localparam int MAP_W   = N_TERMS * N_COLS;
    localparam int CFG_W   = MAP_W + N_OUT;

    logic [CFG_W-1:0]  act_cfg;
    logic [N_COLS-1:0] col_vec;

    for (genvar i = 0; i < N_IN; i++) begin : g_col
        assign col_vec[2*i +: 2] = sop_pkg::col_pair(in_i[i]);
    end

    sop_cfg_store #(.W(CFG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdi_i    (cfg_sdi_i),
        .shift_i  (cfg_shift_i),
        .load_i   (cfg_load_i),
        .active_o (act_cfg)
    );

    sop_and_plane #(.N_COLS(N_COLS), .N_TERMS(N_TERMS)) u_and (
        .cols_i  (col_vec),
        .map_i   (act_cfg[CFG_W-1:N_OUT]),
        .pterm_o (pterm_o)
    );

    sop_or_plane #(.N_OUT(N_OUT), .TPO(TPO)) u_or (
        .pterm_i    (pterm_o),
        .mode_i     (act_cfg[N_OUT-1:0]),
        .sum_o      (sum_o),
        .sum_mask_o (sum_mask_o),
        .oe_term_o  (oe_term_o)
    );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_OUT  = 8,
    parameter int TPO    = 8,
    parameter int N_COLS = 32
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  cfg_load_i,
    input logic [N_OUT*TPO*N_COLS+N_OUT-1:0]     act_cfg,
    input logic [N_OUT*TPO-1:0]                  pterm_o,
    input logic [N_OUT-1:0]                      sum_o,
    input logic [N_OUT*TPO-1:0]                  sum_mask_o,
    input logic [N_OUT-1:0]                      oe_term_o
);

    localparam int N_TERMS = N_OUT * TPO;

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load_i |=> $stable(act_cfg));

    for (genvar t = 0; t < N_TERMS; t++) begin : g_t
        // R2
        empty_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act_cfg[N_OUT + t*N_COLS +: N_COLS] == '0) |-> pterm_o[t]);
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        // R4
        sum_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sum_o[o] == |(pterm_o[o*TPO +: TPO] & sum_mask_o[o*TPO +: TPO]));
        // R5
        all_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !act_cfg[o] |-> (sum_mask_o[o*TPO +: TPO] == '1) && !oe_term_o[o]);
        // R6
        split_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            act_cfg[o] |-> (oe_term_o[o] == pterm_o[o*TPO + TPO - 1])
                           && !sum_mask_o[o*TPO + TPO - 1]);
    end

endmodule

bind sop_array sop_array_chk #(.N_OUT(N_OUT), .TPO(TPO), .N_COLS(N_COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_load_i (cfg_load_i),
    .act_cfg    (act_cfg),
    .pterm_o    (pterm_o),
    .sum_o      (sum_o),
    .sum_mask_o (sum_mask_o),
    .oe_term_o  (oe_term_o)
);

// File: tb/sop_array_tb.sv
module sop_array_tb;

    localparam int N_IN    = 16;
    localparam int N_OUT   = 8;
    localparam int TPO     = 8;
    localparam int N_COLS  = 2 * N_IN;
    localparam int N_TERMS = N_OUT * TPO;
    localparam int CFG_W   = N_TERMS * N_COLS + N_OUT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_IN-1:0] in_r = '0;
    logic sdi = 1'b0, shift = 1'b0, load = 1'b0;
    logic [N_TERMS-1:0] pterm, mask;
    logic [N_OUT-1:0]   sum, oe;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    logic [CFG_W-1:0] m_shadow = '0, m_active = '0, nxt;

    always #5 clk = ~clk;

    sop_array #(.N_IN(N_IN), .N_OUT(N_OUT), .TPO(TPO)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_i(in_r),
        .cfg_sdi_i(sdi), .cfg_shift_i(shift), .cfg_load_i(load),
        .pterm_o(pterm), .sum_o(sum), .sum_mask_o(mask), .oe_term_o(oe)
    );

    function automatic int idx(int t, int c);
        return N_OUT + t*N_COLS + c;
    endfunction

    // R1 column order, R2/R3 follow from the AND over connected columns
    function automatic bit exp_term(logic [CFG_W-1:0] cfg, int t, logic [N_IN-1:0] x);
        for (int c = 0; c < N_COLS; c++) begin
            bit v = (c % 2 == 1) ? ~x[c/2] : x[c/2];
            if (cfg[idx(t, c)] && !v) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check_out(string tag);
        logic [N_TERMS-1:0] ept, emask;
        logic [N_OUT-1:0]   esum, eoe;
        @(negedge clk);
        #1;
        for (int t = 0; t < N_TERMS; t++) ept[t] = exp_term(m_active, t, in_r);
        for (int o = 0; o < N_OUT; o++) begin
            bit split = m_active[o];
            for (int s = 0; s < TPO; s++) emask[o*TPO+s] = !(split && s == TPO-1);
            esum[o] = |(ept[o*TPO +: TPO] & emask[o*TPO +: TPO]);
            eoe[o]  = split & ept[o*TPO+TPO-1];
        end
        n_tests++;
        if (pterm !== ept || sum !== esum || mask !== emask || oe !== eoe) begin
            n_fail++;
            $display("FAIL %s in=%h pterm=%h/%h sum=%h/%h mask=%h/%h oe=%h/%h (actual/expected)",
                     tag, in_r, pterm, ept, sum, esum, mask, emask, oe, eoe);
        end
    endtask

    task automatic set_in(logic [N_IN-1:0] x, string tag);
        @(negedge clk);
        in_r = x;
        check_out(tag);
    endtask

    task automatic push(bit b, bit ld);
        @(negedge clk);
        sdi = b; shift = 1'b1; load = ld;
        @(posedge clk);
        if (ld) m_active = m_shadow;
        m_shadow = {m_shadow[CFG_W-2:0], b};
        #1;
        shift = 1'b0; load = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        load = 1'b1;
        @(posedge clk);
        m_active = m_shadow;
        #1;
        load = 1'b0;
    endtask

    // R8: MSB first
    task automatic load_cfg(logic [CFG_W-1:0] v);
        for (int k = CFG_W-1; k >= 0; k--) push(v[k], 1'b0);
        strobe();
    endtask

    initial begin
        void'($urandom(32'h5EED_0101));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset state
        set_in(16'h0000, "R9 reset");
        set_in(16'hA5C3, "R9 reset");

        // Directed map
        nxt = '0;
        nxt[1] = 1'b1; nxt[3] = 1'b1;            // outputs 1 and 3 split
        // term0 empty (R2); term1 contradictory on input 0 (R3)
        nxt[idx(1,0)] = 1'b1; nxt[idx(1,1)] = 1'b1;
        // term2 = in0 & ~in1 (R1)
        nxt[idx(2,0)] = 1'b1; nxt[idx(2,3)] = 1'b1;
        // term7 = in2 (last slot of output 0, all-sum, R5)
        nxt[idx(7,4)] = 1'b1;
        // term15 = ~in15 (last slot of output 1, split, R6)
        nxt[idx(15,31)] = 1'b1;
        // term8 contradictory on input 15; others in group 1 fill with it
        for (int s = 8; s < 15; s++) begin
            nxt[idx(s,30)] = 1'b1; nxt[idx(s,31)] = 1'b1;
        end
        // output 3 group all contradictory except split slot empty
        for (int s = 24; s < 31; s++) begin
            nxt[idx(s,2)] = 1'b1; nxt[idx(s,3)] = 1'b1;
        end
        load_cfg(nxt);
        set_in(16'h0000, "R1 R2 R3 R6 directed");
        set_in(16'hFFFF, "R1 R3 R6 directed");
        set_in(16'h0001, "R1 in0 true column");
        set_in(16'h0003, "R1 in1 complement column");
        set_in(16'h8004, "R5 R6 last slot");
        set_in(16'h7FFF, "R6 enable term from split slot");
        set_in(16'h0005, "R4 R5 group sum");

        // R7: partial shift must leave outputs unchanged
        for (int k = 0; k < 300; k++) push(1'b1, 1'b0);
        set_in(16'h0001, "R7 partial shift");
        set_in(16'hFFFF, "R7 partial shift");
        for (int k = 300; k < CFG_W; k++) push(k[0], 1'b0);
        set_in(16'h1234, "R7 full shift before strobe");
        strobe();
        set_in(16'h1234, "R7 after strobe");
        set_in(16'hFEDC, "R7 after strobe");

        // R10: shift and load together
        nxt = '0;
        for (int t = 0; t < N_TERMS; t++) nxt[idx(t, t % N_COLS)] = 1'b1;
        nxt[N_OUT-1:0] = 8'h5A;
        load_cfg(nxt);
        push(1'b1, 1'b1);
        set_in(16'h00FF, "R10 load with shift");
        set_in(16'hFF00, "R10 load with shift");
        strobe();
        set_in(16'h00FF, "R10 shifted map loaded");
        set_in(16'h0F0F, "R10 shifted map loaded");

        // Random sparse maps with random modes
        for (int r = 0; r < 12; r++) begin
            nxt = '0;
            nxt[N_OUT-1:0] = N_OUT'($urandom);
            for (int t = 0; t < N_TERMS; t++)
                for (int c = 0; c < N_COLS; c++)
                    nxt[idx(t,c)] = ($urandom % 14 == 0);
            load_cfg(nxt);
            for (int v = 0; v < 24; v++)
                set_in(N_IN'($urandom), "R1 R2 R3 R4 R5 R6 R8 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule